// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Slave Controller

This block is a slave on a two-wire serial bus (I2C/SMBus style) that fronts a small bank of 16-bit registers. A fast system clock samples the bus clock and data lines through synchronizers. Edges of the bus clock are detected on those synchronized samples, as are the start and stop conditions. The slave drives the data line only by enabling an open-drain pull-down. It never drives the line high.

Registers are reached indirectly, through a pointer byte. In a write transaction, the first byte after the address byte loads the pointer. Any bytes after that write the selected register, high byte first. In a read transaction, the slave returns the selected register, high byte first. The pointer keeps its value across transactions, so repeated reads need no new pointer write.

The 7-bit slave address is picked from nine values by two three-level strap inputs. The straps are decoded once, when the block leaves reset.

Top module: `ptr_i2c_slave`

The sequencer states are:
- IDLE: bus free.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging the address.
- PTR: shifting in the pointer byte.
- PTR_ACK: acknowledging the pointer.
- WDATA: shifting in a write byte.
- WDATA_ACK: acknowledging a write byte.
- RDATA: shifting out a read byte.
- RACK: sampling the master's acknowledge.
- IGNORE: waiting for the next START or STOP.

Transitions:
- START moves any state to ADDR. STOP moves any state to IDLE.
- ADDR goes to ADDR_ACK on an address match and to IGNORE on a mismatch, at the falling clock edge after the 8th bit.
- ADDR_ACK goes to RDATA when the direction bit is 1 and to PTR when it is 0.
- PTR goes to PTR_ACK, then to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RACK after 8 bits.
- RACK goes back to RDATA on an ACK and to IGNORE on a NACK.

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), the pointer is 0, and register i holds {8'hA0+i, 8'h50+i}.
- R2: SDA falling while SCL is high is a START. It (re)starts address matching from any state, including a repeated START in mid-transaction. SDA rising while SCL is high is a STOP, which returns the slave to idle.
- R3: Each strap input is a 2-bit level code: 00 = low, 01 = high, 1x = floating. With the index = 3*level(strap1) + level(strap0), where low=0, high=1, float=2, the address is taken in index order from 1001100, 1001101, 1001110, 1001111, 1001000, 1001001, 1001010, 1001011, 0110111. The straps are decoded once on leaving reset; later changes have no effect.
- R4: The first byte after START is 7 address bits, MSB first, then the direction bit (0 = write, 1 = read). On a match, the slave pulls SDA low during the 9th clock. On a mismatch, it does not acknowledge that byte or any byte before the next START.
- R5: In a write, the first byte after the address byte loads the pointer and is acknowledged. A transaction carrying only the pointer byte is valid.
- R6: Write data bytes after the pointer arrive high byte then low byte, and each is acknowledged. The register updates only when the low byte completes, so a lone high byte leaves it unchanged.
- R7: A read returns the pointed register MSB first, high byte then low byte. Further acknowledged bytes keep alternating high and low of the same register.
- R8: The pointer persists across STOP and new transactions, so a repeated read without a pointer write returns the same register.
- R9: A master NACK after a read byte ends transmission. SDA stays released until the next START or STOP.
- R10: A pointer value of 4 or more, with 4 registers, reads as 16'h0000. Writes through such a pointer are acknowledged but change no register.
- R11: SDA is only pulled low, never driven high, and the slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull-down enable for the data line (1 = drive low) |
| strap0_lvl | input | 2 | Level code of address strap 0 |
| strap1_lvl | input | 2 | Level code of address strap 1 |

## Verification
The hardest case to reach from the ports is what the slave does after a master NACK. At that point the slave must have let go of SDA even though its next byte would begin with a 0 bit. The bench reaches it by pointing at a register whose low byte has a zero MSB, NACKing the high byte, and then clocking one more bit with the master released; the line must read high. Repeated START and strap latching are also driven on purpose: a START is issued straight after a pointer byte with no STOP, and the straps are changed after reset while the bench confirms the old address still answers.

// File: rtl/ptr_i2c_pkg.sv
package ptr_i2c_pkg;

    localparam int unsigned REG_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bus_state_t;

    // Level code: 00 low, 01 high, 1x floating -> 0, 1, 2
    function automatic logic [1:0] strap_level(input logic [1:0] code);
        return code[1] ? 2'd2 : {1'b0, code[0]};
    endfunction

    function automatic logic [6:0] strap_addr(input logic [1:0] s1, input logic [1:0] s0);
        logic [3:0] idx;
        idx = 4'(strap_level(s1)) * 4'd3 + 4'(strap_level(s0));
        case (idx)
            4'd0:    return 7'b1001100;
            4'd1:    return 7'b1001101;
            4'd2:    return 7'b1001110;
            4'd3:    return 7'b1001111;
            4'd4:    return 7'b1001000;
            4'd5:    return 7'b1001001;
            4'd6:    return 7'b1001010;
            4'd7:    return 7'b1001011;
            default: return 7'b0110111;
        endcase
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;
    assign start_o  = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_o   = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_strap_decode.sv
module i2c_strap_decode
    import ptr_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap0_lvl,
    input  logic [1:0] strap1_lvl,
    output logic [6:0] addr_o
);
    logic loaded;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded <= 1'b0;
            addr_o <= '0;
        end else if (!loaded) begin
            loaded <= 1'b1;
            addr_o <= strap_addr(strap1_lvl, strap0_lvl);
        end
    end

    // R3
    addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> $stable(addr_o));
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import ptr_i2c_pkg::*;
#(
    parameter int unsigned NUM_REGS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       waddr,
    input  logic [REG_W-1:0] wdata,
    input  logic [7:0]       raddr,
    output logic [REG_W-1:0] rdata
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [7:0]  NREG8 = 8'(NUM_REGS);

    logic [REG_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= {8'hA0 + 8'(g), 8'h50 + 8'(g)};
            else if (we && waddr == 8'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = (raddr < NREG8) ? regs[raddr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/ptr_i2c_slave.sv
module ptr_i2c_slave
    import ptr_i2c_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap0_lvl,
    input  logic [1:0] strap1_lvl
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] own_addr;
    bus_state_t state_q, state_d;
    logic [3:0] bit_cnt;
    logic [7:0] shreg, tx_q, ptr_q, hold_q;
    logic rw_q, sel_q, nack_q;
    logic reg_we;
    logic [REG_W-1:0] rdata;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_o(start_det), .stop_o(stop_det));

    i2c_strap_decode u_strap (
        .clk(clk), .rst_n(rst_n), .strap0_lvl(strap0_lvl),
        .strap1_lvl(strap1_lvl), .addr_o(own_addr));

    assign reg_we = (state_q == ST_WDATA) && scl_fall && (bit_cnt == 4'd8) && sel_q;

    i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(ptr_q),
        .wdata({hold_q, shreg}), .raddr(ptr_q), .rdata(rdata));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (stop_det)
            state_d = ST_IDLE;
        else if (start_det)
            state_d = ST_ADDR;
        else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR:
                    if (scl_fall && bit_cnt == 4'd8)
                        state_d = (shreg[7:1] == own_addr) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall) state_d = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:
                    if (scl_fall && bit_cnt == 4'd8) state_d = ST_PTR_ACK;
                ST_PTR_ACK:
                    if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:
                    if (scl_fall && bit_cnt == 4'd8) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK:
                    if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:
                    if (scl_fall && bit_cnt == 4'd7) state_d = ST_RACK;
                ST_RACK:
                    if (scl_fall) state_d = nack_q ? ST_IGNORE : ST_RDATA;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            hold_q  <= '0;
            rw_q    <= 1'b0;
            sel_q   <= 1'b0;
            nack_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (scl_fall && bit_cnt == 4'd8) begin
                        if (state_q == ST_ADDR) rw_q <= shreg[0];
                        if (state_q == ST_PTR)  ptr_q <= shreg;
                        if (state_q == ST_WDATA) begin
                            if (!sel_q) hold_q <= shreg;
                            sel_q <= ~sel_q;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    sel_q   <= 1'b0;
                    tx_q    <= rdata[15:8];
                end
                ST_PTR_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    sel_q   <= 1'b0;
                end
                ST_WDATA_ACK: if (scl_fall) bit_cnt <= '0;
                ST_RDATA: if (scl_fall) begin
                    tx_q    <= {tx_q[6:0], 1'b0};
                    bit_cnt <= bit_cnt + 4'd1;
                end
                ST_RACK: begin
                    if (scl_rise) nack_q <= sda_s;
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        sel_q   <= ~sel_q;
                        tx_q    <= sel_q ? rdata[15:8] : rdata[7:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~tx_q[7];
            default:  sda_oe = 1'b0;
        endcase
    end

    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe));

    // R11
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

// File: tb/ptr_i2c_slave_bench.sv
module ptr_i2c_slave_bench;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] s0 = 2'b00, s1 = 2'b00;
    logic sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    ptr_i2c_slave u_ptr_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .strap0_lvl(s0), .strap1_lvl(s1));

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] p1, input logic [1:0] p0);
        rst_n = 1'b0; s1 = p1; s0 = p0; m_scl = 1'b1; m_sda = 1'b1;
        wclk(5); rst_n = 1'b1; wclk(5);
    endtask

    task automatic i2c_start();
        wclk(2); m_sda = 1'b1; wclk(H); m_scl = 1'b1; wclk(H);
        m_sda = 1'b0; wclk(H); m_scl = 1'b0;
    endtask

    task automatic i2c_stop();
        wclk(2); m_sda = 1'b0; wclk(H); m_scl = 1'b1; wclk(H);
        m_sda = 1'b1; wclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wclk(2); m_sda = b[i]; wclk(H); m_scl = 1'b1; wclk(H); m_scl = 1'b0;
        end
        wclk(2); m_sda = 1'b1; wclk(H); m_scl = 1'b1; wclk(H/2);
        ack = ~sda_bus; wclk(H/2); m_scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        wclk(2); m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(H); m_scl = 1'b1; wclk(H/2); b[i] = sda_bus; wclk(H/2); m_scl = 1'b0;
        end
        wclk(2); m_sda = ~give_ack; wclk(H); m_scl = 1'b1; wclk(H); m_scl = 1'b0;
        wclk(2); m_sda = 1'b1;
    endtask

    // Pointer-only write, optional stop
    task automatic set_ptr(input logic [6:0] a, input logic [7:0] p, input string tag);
        logic ack;
        i2c_start();
        send_byte({a, 1'b0}, ack); check({tag, " addr ack R4"}, 16'(ack), 16'd1);
        send_byte(p, ack);         check({tag, " ptr ack R5"}, 16'(ack), 16'd1);
    endtask

    task automatic read_word(input logic [6:0] a, output logic [15:0] w);
        logic ack; logic [7:0] hi, lo;
        i2c_start();
        send_byte({a, 1'b1}, ack); check("read addr ack R4", 16'(ack), 16'd1);
        recv_byte(hi, 1'b1); recv_byte(lo, 1'b0);
        i2c_stop();
        w = {hi, lo};
    endtask

    task automatic t_reset_state();
        check("R1 sda released after reset", 16'(sda_oe), 16'd0);
        check("R11 bus high after reset", 16'(sda_bus), 16'd1);
    endtask

    task automatic t_default_read();
        logic [15:0] w;
        read_word(7'h4C, w);
        check("R1 pointer 0 reg0 reset value (R7)", w, 16'hA050);
    endtask

    task automatic t_ptr_read();
        logic [15:0] w; logic ack; logic [7:0] hi, lo;
        set_ptr(7'h4C, 8'd2, "rs");
        i2c_start(); // repeated START, no STOP
        send_byte({7'h4C, 1'b1}, ack); check("R2 repeated start addr ack", 16'(ack), 16'd1);
        recv_byte(hi, 1'b1); recv_byte(lo, 1'b0); i2c_stop();
        check("R7 reg2 via repeated start", {hi, lo}, 16'hA252);
        read_word(7'h4C, w);
        check("R8 pointer persists", w, 16'hA252);
    endtask

    task automatic t_write_reg();
        logic ack; logic [15:0] w;
        set_ptr(7'h4C, 8'd1, "wr");
        send_byte(8'h12, ack); check("R6 high byte ack", 16'(ack), 16'd1);
        send_byte(8'h34, ack); check("R6 low byte ack", 16'(ack), 16'd1);
        i2c_stop();
        read_word(7'h4C, w);
        check("R6 reg1 written", w, 16'h1234);
        set_ptr(7'h4C, 8'd3, "half");
        send_byte(8'h77, ack); i2c_stop();
        read_word(7'h4C, w);
        check("R6 lone high byte no update", w, 16'hA353);
    endtask

    task automatic t_addr_mismatch();
        logic ack;
        i2c_start();
        send_byte({7'h48, 1'b0}, ack); check("R4 mismatch no ack", 16'(ack), 16'd0);
        send_byte(8'h00, ack);         check("R4 ignored byte no ack", 16'(ack), 16'd0);
        i2c_stop();
    endtask

    task automatic t_out_of_range();
        logic ack; logic [15:0] w;
        set_ptr(7'h4C, 8'd9, "oor");
        send_byte(8'hDE, ack); check("R10 oor data ack", 16'(ack), 16'd1);
        send_byte(8'hAD, ack); i2c_stop();
        read_word(7'h4C, w);
        check("R10 oor reads zero", w, 16'h0000);
        set_ptr(7'h4C, 8'd0, "oor0"); i2c_stop();
        read_word(7'h4C, w);
        check("R10 reg0 untouched", w, 16'hA050);
    endtask

    task automatic t_long_read();
        logic ack; logic [7:0] b0, b1, b2;
        set_ptr(7'h4C, 8'd2, "long");
        i2c_start();
        send_byte({7'h4C, 1'b1}, ack);
        recv_byte(b0, 1'b1); recv_byte(b1, 1'b1); recv_byte(b2, 1'b0); i2c_stop();
        check("R7 byte0 high", 16'(b0), 16'hA2);
        check("R7 byte1 low", 16'(b1), 16'h52);
        check("R7 byte2 wraps to high", 16'(b2), 16'hA2);
    endtask

    task automatic t_nack_release();
        logic ack; logic [7:0] hi; logic bit0;
        set_ptr(7'h4C, 8'd0, "nack"); i2c_stop();
        i2c_start();
        send_byte({7'h4C, 1'b1}, ack);
        recv_byte(hi, 1'b0);
        check("R9 high byte before nack", 16'(hi), 16'hA0);
        wclk(H); m_scl = 1'b1; wclk(H/2); bit0 = sda_bus; wclk(H/2); m_scl = 1'b0;
        check("R9 sda released after nack", 16'(bit0), 16'd1);
        i2c_stop();
    endtask

    task automatic t_straps();
        logic ack;
        do_reset(2'b01, 2'b00);
        i2c_start(); send_byte({7'h4F, 1'b0}, ack); i2c_stop();
        check("R3 high/low strap address 4F", 16'(ack), 16'd1);
        i2c_start(); send_byte({7'h4C, 1'b0}, ack); i2c_stop();
        check("R3 old address rejected", 16'(ack), 16'd0);
        s1 = 2'b00; s0 = 2'b00; wclk(10);
        i2c_start(); send_byte({7'h4F, 1'b0}, ack); i2c_stop();
        check("R3 straps not resampled", 16'(ack), 16'd1);
        do_reset(2'b10, 2'b11);
        i2c_start(); send_byte({7'h37, 1'b0}, ack); i2c_stop();
        check("R3 float/float address 37", 16'(ack), 16'd1);
        do_reset(2'b00, 2'b00);
        i2c_start(); send_byte({7'h4C, 1'b0}, ack); i2c_stop();
        check("R3 low/low address 4C", 16'(ack), 16'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        do_reset(2'b00, 2'b00);
        t_reset_state();
        t_default_read();
        t_ptr_read();
        t_write_reg();
        t_addr_mismatch();
        t_out_of_range();
        t_long_read();
        t_nack_release();
        t_straps();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule